// File: doc/BRIEF.md
# Capture-Compare Timer on a Byte-Wide Register Bus

This block is a 16-bit up-counter with two output compare channels and one input capture register, controlled by a processor over an 8-bit register bus. Each compare channel watches the running count. On a match it raises its own flag and toggles its own waveform pin. The capture register takes a snapshot of the count on a rising edge of an event source. That source is chosen between an external pin and an analog comparator output. In an alternative mode the capture register instead sets the wrap point of the counter.

A 16-bit register cannot be moved in one transfer over a byte bus. To keep each 16-bit access atomic, the block has one 8-bit holding register shared by all 16-bit registers. Software writes the high byte first, which fills only the holding register. The following low-byte write then updates all sixteen bits in one cycle. For reads, software reads the low byte first. That read also copies the matching high byte into the holding register, so a later high-byte read returns half of the same sample.

Four event flags (overflow, compare A, compare B, capture) are cleared by writing one to them. Each flag is gated into its own interrupt line by a mask bit and by a global enable input.

Top module: `cc_timer`

## Requirements
- R1: After reset, the counter, both compare registers, the capture register, the holding register, the mask, the flags, the control register and both waveform pins are all zero.
- R2: The mask register (address 8) implements bit 0 overflow, bit 1 compare A, bit 2 compare B and bit 5 capture. Bits 3, 4, 6 and 7 always read as zero, whatever was written.
- R3: The 16-bit registers sit at address pairs. The low byte is at the even address and the high byte at the odd address: counter 0/1, compare A 2/3, compare B 4/5, capture 6/7. A write to an odd address changes only the holding register. A write to an even address loads {holding, written byte} into the target in one cycle.
- R4: A read of an even address returns the target's low byte and copies its high byte into the holding register. A read of an odd address returns the holding register. A low read followed by a high read therefore returns one coherent 16-bit sample, even while the counter runs.
- R5: The control register is at address 10. When its bit 0 (run) is one, the counter advances by one each clock. When run is zero the counter holds. A bus write to the counter takes priority over counting.
- R6: While running, the cycle after the count equals a compare value, that channel's flag is set and its waveform pin toggles. Compare A uses flag bit 1 and pin wave_a. Compare B uses flag bit 2 and pin wave_b.
- R7: When the counter wraps from its top value to zero, the overflow flag (bit 0) is set. The top value is 0xFFFF in normal mode.
- R8: On a rising edge of the selected event source, the capture register loads the counter value and the capture flag (bit 5) is set. The edge is seen after a two-flop synchroniser. Control bit 1 selects the source: 0 for cap_pin, 1 for cmp_event. The source that is not selected has no effect.
- R9: When control bit 2 is one, the capture register is the counter's top value. The counter wraps to zero after reaching it and sets the overflow flag. Capture events are ignored in this mode.
- R10: Each interrupt output is high exactly when its flag is set, its mask bit is one and gie is high.
- R11: The flag register is at address 9, with the same bit positions as the mask. Writing one to a bit clears that flag. Writing zero leaves it unchanged. If a flag is set and cleared in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe, one cycle per byte |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high, zero otherwise |
| cap_pin | input | 1 | External capture event |
| cmp_event | input | 1 | Analog comparator output used as a capture event |
| gie | input | 1 | Global interrupt enable |
| wave_a | output | 1 | Compare A waveform pin |
| wave_b | output | 1 | Compare B waveform pin |
| irq_ovf | output | 1 | Overflow interrupt request |
| irq_cmpa | output | 1 | Compare A interrupt request |
| irq_cmpb | output | 1 | Compare B interrupt request |
| irq_cap | output | 1 | Capture interrupt request |

## Verification
Two collisions are provoked on purpose. The first is a hardware flag set meeting a software write-one clear. The bench raises cap_pin, counts the two synchroniser stages, and issues the clear of bit 5 on exactly the edge where the capture lands. The flag must read back as one afterwards, and a later lone clear must drop it. The second is a counter advance meeting a split 16-bit read. The low byte is read on the cycle the count is 0x12FF, and the high byte is read after the count has moved to 0x1300. The returned word must be 0x12FF, not a mix of the two values.

// File: rtl/cc_timer_pkg.sv
package cc_timer_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;
    localparam int ADDR_W = 4;
    localparam int NSRC   = 4;
    localparam int NCMP   = 2;

    typedef logic [CNT_W-1:0]  word_t;
    typedef logic [BYTE_W-1:0] byte_t;

    localparam logic [ADDR_W-1:0] ADR_MASK = 4'd8;
    localparam logic [ADDR_W-1:0] ADR_FLAG = 4'd9;
    localparam logic [ADDR_W-1:0] ADR_CTRL = 4'd10;

    localparam byte_t MASK_IMPL = 8'h27;

    typedef enum logic [1:0] {
        T_CNT  = 2'd0,
        T_CMPA = 2'd1,
        T_CMPB = 2'd2,
        T_CAP  = 2'd3
    } tgt_e;

    typedef struct packed {
        logic top_mode;
        logic src_cmp;
        logic run;
    } ctrl_t;

    typedef struct packed {
        logic  valid;
        tgt_e  tgt;
        word_t data;
    } wr16_t;

    // source index 0 ovf, 1 cmpa, 2 cmpb, 3 cap
    function automatic int flag_pos(input int idx);
        return (idx == 3) ? 5 : idx;
    endfunction

endpackage

// File: rtl/cc_bus_regs.sv
module cc_bus_regs
    import cc_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  byte_t             wdata,
    input  logic              rd,
    output byte_t             rdata,
    input  word_t             cnt,
    input  word_t             cap,
    input  byte_t             flags,
    output wr16_t             wr16,
    output word_t             cmp_a,
    output word_t             cmp_b,
    output ctrl_t             ctrl,
    output byte_t             mask,
    output byte_t             flag_clr
);

    byte_t hold_q;
    word_t cmpa_q, cmpb_q;
    ctrl_t ctrl_q;
    byte_t mask_q;
    word_t sel_word;
    tgt_e  tgt;
    logic  wide, hi;

    assign wide = ~addr[ADDR_W-1];
    assign hi   = addr[0];
    assign tgt  = tgt_e'(addr[2:1]);

    always_comb begin
        case (tgt)
            T_CNT:   sel_word = cnt;
            T_CMPA:  sel_word = cmpa_q;
            T_CMPB:  sel_word = cmpb_q;
            default: sel_word = cap;
        endcase
    end

    always_comb begin
        wr16.valid = wr && wide && !hi;
        wr16.tgt   = tgt;
        wr16.data  = {hold_q, wdata};
    end

    always_comb begin
        rdata = '0;
        if (rd) begin
            if (wide)
                rdata = hi ? hold_q : sel_word[BYTE_W-1:0];
            else if (addr == ADR_MASK)
                rdata = mask_q;
            else if (addr == ADR_FLAG)
                rdata = flags;
            else if (addr == ADR_CTRL)
                rdata = {{(BYTE_W-3){1'b0}}, ctrl_q};
        end
    end

    assign flag_clr = (wr && addr == ADR_FLAG) ? wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            cmpa_q <= '0;
            cmpb_q <= '0;
            ctrl_q <= '0;
            mask_q <= '0;
        end else begin
            if (rd && wide && !hi)
                hold_q <= sel_word[CNT_W-1:BYTE_W];
            if (wr && wide && hi)
                hold_q <= wdata;
            if (wr16.valid && tgt == T_CMPA)
                cmpa_q <= wr16.data;
            if (wr16.valid && tgt == T_CMPB)
                cmpb_q <= wr16.data;
            if (wr && addr == ADR_MASK)
                mask_q <= wdata & MASK_IMPL;
            if (wr && addr == ADR_CTRL)
                ctrl_q <= ctrl_t'(wdata[2:0]);
        end
    end

    assign cmp_a = cmpa_q;
    assign cmp_b = cmpb_q;
    assign ctrl  = ctrl_q;
    assign mask  = mask_q;

endmodule

// File: rtl/cc_count_core.sv
module cc_count_core
    import cc_timer_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  ctrl_t            ctrl,
    input  word_t            top_val,
    input  wr16_t            wr16,
    input  word_t            cmp_a,
    input  word_t            cmp_b,
    output word_t            cnt,
    output logic [NCMP-1:0]  wave,
    output logic [NCMP-1:0]  hit,
    output logic             wrap
);

    word_t cnt_q;
    word_t top;
    logic  cnt_wr;
    word_t cmp [NCMP];

    assign cmp[0] = cmp_a;
    assign cmp[1] = cmp_b;

    assign top    = ctrl.top_mode ? top_val : '1;
    assign cnt_wr = wr16.valid && wr16.tgt == T_CNT;
    assign wrap   = ctrl.run && !cnt_wr && cnt_q == top;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (cnt_wr)
            cnt_q <= wr16.data;
        else if (ctrl.run)
            cnt_q <= (cnt_q == top) ? '0 : cnt_q + 1'b1;
    end

    for (genvar i = 0; i < NCMP; i++) begin : g_ch
        logic wave_q;
        assign hit[i] = ctrl.run && cnt_q == cmp[i];
        always_ff @(posedge clk) begin
            if (rst)
                wave_q <= 1'b0;
            else if (hit[i])
                wave_q <= ~wave_q;
        end
        assign wave[i] = wave_q;
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/cc_capture_unit.sv
module cc_capture_unit
    import cc_timer_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  pin,
    input  logic  cmp_in,
    input  ctrl_t ctrl,
    input  word_t cnt,
    input  wr16_t wr16,
    output word_t cap,
    output logic  cap_evt
);

    logic [2:0] sync_q;
    logic       src;
    word_t      cap_q;

    assign src     = ctrl.src_cmp ? cmp_in : pin;
    assign cap_evt = sync_q[1] && !sync_q[2] && !ctrl.top_mode;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            cap_q  <= '0;
        end else begin
            sync_q <= {sync_q[1:0], src};
            if (cap_evt)
                cap_q <= cnt;
            else if (wr16.valid && wr16.tgt == T_CAP)
                cap_q <= wr16.data;
        end
    end

    assign cap = cap_q;

endmodule

// File: rtl/cc_irq_ctrl.sv
module cc_irq_ctrl
    import cc_timer_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] set,
    input  byte_t           clr,
    input  byte_t           mask,
    input  logic            gie,
    output byte_t           flags,
    output logic [NSRC-1:0] irq
);

    logic [NSRC-1:0] flag_q;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        localparam int P = flag_pos(i);
        always_ff @(posedge clk) begin
            if (rst)
                flag_q[i] <= 1'b0;
            else if (set[i])
                flag_q[i] <= 1'b1;
            else if (clr[P])
                flag_q[i] <= 1'b0;
        end
        assign irq[i] = flag_q[i] && mask[P] && gie;
    end

    always_comb begin
        flags = '0;
        for (int i = 0; i < NSRC; i++)
            flags[flag_pos(i)] = flag_q[i];
    end

endmodule

// File: rtl/cc_timer.sv
module cc_timer
    import cc_timer_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] bus_addr,
    input  logic       bus_wr,
    input  logic [7:0] bus_wdata,
    input  logic       bus_rd,
    output logic [7:0] bus_rdata,
    input  logic       cap_pin,
    input  logic       cmp_event,
    input  logic       gie,
    output logic       wave_a,
    output logic       wave_b,
    output logic       irq_ovf,
    output logic       irq_cmpa,
    output logic       irq_cmpb,
    output logic       irq_cap
);

    wr16_t           wr16;
    word_t           cmp_a, cmp_b, cnt, cap;
    ctrl_t           ctrl;
    byte_t           mask, flags, flag_clr;
    logic [NCMP-1:0] wave, hit;
    logic            wrap, cap_evt;
    logic [NSRC-1:0] irq;
    logic            cnt_wr_s, cap_wr_s;

    assign cnt_wr_s = wr16.valid && wr16.tgt == T_CNT;
    assign cap_wr_s = wr16.valid && wr16.tgt == T_CAP;

    cc_bus_regs u_bus (
        .clk(clk), .rst(rst), .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata),
        .rd(bus_rd), .rdata(bus_rdata), .cnt(cnt), .cap(cap), .flags(flags),
        .wr16(wr16), .cmp_a(cmp_a), .cmp_b(cmp_b), .ctrl(ctrl), .mask(mask),
        .flag_clr(flag_clr)
    );

    cc_count_core u_core (
        .clk(clk), .rst(rst), .ctrl(ctrl), .top_val(cap), .wr16(wr16),
        .cmp_a(cmp_a), .cmp_b(cmp_b), .cnt(cnt), .wave(wave), .hit(hit),
        .wrap(wrap)
    );

    cc_capture_unit u_cap (
        .clk(clk), .rst(rst), .pin(cap_pin), .cmp_in(cmp_event), .ctrl(ctrl),
        .cnt(cnt), .wr16(wr16), .cap(cap), .cap_evt(cap_evt)
    );

    cc_irq_ctrl u_irq (
        .clk(clk), .rst(rst), .set({cap_evt, hit[1], hit[0], wrap}),
        .clr(flag_clr), .mask(mask), .gie(gie), .flags(flags), .irq(irq)
    );

    assign wave_a   = wave[0];
    assign wave_b   = wave[1];
    assign irq_ovf  = irq[0];
    assign irq_cmpa = irq[1];
    assign irq_cmpb = irq[2];
    assign irq_cap  = irq[3];

endmodule

// File: rtl/cc_timer_chk.sv
module cc_timer_chk (
    input logic        clk,
    input logic        rst,
    input logic        gie,
    input logic        irq_cap,
    input logic        irq_cmpa,
    input logic [7:0]  mask,
    input logic [7:0]  flags,
    input logic        run,
    input logic        top_mode,
    input logic        cnt_wr,
    input logic        cap_wr,
    input logic [15:0] cnt,
    input logic [15:0] cap,
    input logic [15:0] cmpa,
    input logic        wave_a,
    input logic        cap_evt
);

    always_comb begin
        if (!rst) begin
            a_r2_reserved_zero: assert ((mask & 8'hD8) == 8'h00);
        end
    end

    a_r5_hold_when_stopped: assert property (@(posedge clk) disable iff (rst)
        (!run && !cnt_wr) |=> $stable(cnt));

    a_r6_toggle_on_match: assert property (@(posedge clk) disable iff (rst)
        (run && cnt == cmpa) |=> (wave_a != $past(wave_a)));

    a_r6_no_toggle_otherwise: assert property (@(posedge clk) disable iff (rst)
        !(run && cnt == cmpa) |=> $stable(wave_a));

    a_r9_stay_below_top: assert property (@(posedge clk) disable iff (rst)
        (top_mode && run && !cnt_wr && !cap_wr && cnt <= cap) |=> (cnt <= cap));

    a_r10_cap_gate: assert property (@(posedge clk) disable iff (rst)
        irq_cap |-> (gie && mask[5] && flags[5]));

    a_r10_cmpa_gate: assert property (@(posedge clk) disable iff (rst)
        irq_cmpa |-> (gie && mask[1] && flags[1]));

    a_r11_set_wins: assert property (@(posedge clk) disable iff (rst)
        cap_evt |=> flags[5]);

endmodule

bind cc_timer cc_timer_chk u_chk (
    .clk(clk), .rst(rst), .gie(gie), .irq_cap(irq_cap), .irq_cmpa(irq_cmpa),
    .mask(mask), .flags(flags), .run(ctrl.run), .top_mode(ctrl.top_mode),
    .cnt_wr(cnt_wr_s), .cap_wr(cap_wr_s), .cnt(cnt), .cap(cap), .cmpa(cmp_a),
    .wave_a(wave_a), .cap_evt(cap_evt)
);

// File: tb/sim_cc_timer.sv
`timescale 1ns/1ps
module sim_cc_timer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_rdata;
    logic       cap_pin = 1'b0;
    logic       cmp_event = 1'b0;
    logic       gie = 1'b0;
    logic       wave_a, wave_b, irq_ovf, irq_cmpa, irq_cmpb, irq_cap;

    int n_chk = 0;
    int n_err = 0;

    cc_timer u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .cap_pin(cap_pin), .cmp_event(cmp_event), .gie(gie),
        .wave_a(wave_a), .wave_b(wave_b), .irq_ovf(irq_ovf),
        .irq_cmpa(irq_cmpa), .irq_cmpb(irq_cmpb), .irq_cap(irq_cap)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr8(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd8(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wr16(input logic [3:0] lo_a, input logic [15:0] v);
        wr8(lo_a + 4'd1, v[15:8]);
        wr8(lo_a, v[7:0]);
    endtask

    task automatic rd16(input logic [3:0] lo_a, output logic [15:0] v);
        logic [7:0] lo, hi;
        rd8(lo_a, lo);
        rd8(lo_a + 4'd1, hi);
        v = {hi, lo};
    endtask

    task automatic pulse(input bit use_cmp);
        @(negedge clk);
        if (use_cmp) cmp_event = 1'b1; else cap_pin = 1'b1;
        repeat (4) @(negedge clk);
        cmp_event = 1'b0; cap_pin = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    function automatic logic [7:0] mask_expect(input logic [7:0] w);
        return w & 8'h27;
    endfunction

    initial begin
        #(200000 * 20);
        n_err++;
        $display("FAIL watchdog: actual=%h expected=%h", 1'b0, 1'b1);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [15:0] v, w;
        logic [7:0]  b;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd16(4'd0, v); chk("R1 counter", v, 16'h0000);
        rd16(4'd2, v); chk("R1 cmpa", v, 16'h0000);
        rd16(4'd4, v); chk("R1 cmpb", v, 16'h0000);
        rd16(4'd6, v); chk("R1 capture", v, 16'h0000);
        rd8(4'd8, b);  chk("R1 mask", {8'h0, b}, 16'h0000);
        rd8(4'd9, b);  chk("R1 flags", {8'h0, b}, 16'h0000);
        chk("R1 waves", {14'h0, wave_b, wave_a}, 16'h0000);

        // R2 reserved mask bits
        wr8(4'd8, 8'hFF); rd8(4'd8, b); chk("R2 mask ff", {8'h0, b}, {8'h0, mask_expect(8'hFF)});
        wr8(4'd8, 8'hD8); rd8(4'd8, b); chk("R2 mask d8", {8'h0, b}, 16'h0000);

        // R3 high write alone does not commit
        wr8(4'd3, 8'hAB); rd16(4'd2, v); chk("R3 high only", v, 16'h0000);
        wr16(4'd2, 16'hAB5C); rd16(4'd2, v); chk("R3 commit", v, 16'hAB5C);

        // R3 and R4 random round trips, counter stopped, no events
        for (int i = 0; i < 24; i++) begin
            logic [3:0] a;
            a = 4'((($urandom % 4)) * 2);
            w = 16'($urandom);
            wr16(a, w);
            rd16(a, v);
            chk("R3 R4 random", v, w);
        end

        // R4 coherence while counting across a byte carry
        wr16(4'd0, 16'h12FE);
        wr8(4'd10, 8'h01);
        rd16(4'd0, v);
        chk("R4 coherent", v, 16'h12FF);
        wr8(4'd10, 8'h00);

        // R5 hold when stopped, count when running
        wr16(4'd0, 16'h0100);
        repeat (5) @(negedge clk);
        rd16(4'd0, v); chk("R5 hold", v, 16'h0100);

        // R6 compare A match, R10 gating
        wr16(4'd2, 16'h0014);
        wr16(4'd4, 16'h0800);
        wr16(4'd0, 16'h0010);
        wr8(4'd9, 8'hFF);
        wr8(4'd8, 8'h02);
        gie = 1'b1;
        wr8(4'd10, 8'h01);
        repeat (20) @(negedge clk);
        wr8(4'd10, 8'h00);
        rd8(4'd9, b); chk("R6 flag a only", {8'h0, b}, 16'h0002);
        chk("R6 wave a toggled", {15'h0, wave_a}, 16'h0001);
        chk("R6 wave b idle", {15'h0, wave_b}, 16'h0000);
        chk("R10 irq a on", {15'h0, irq_cmpa}, 16'h0001);
        gie = 1'b0; #1;
        chk("R10 gie off", {15'h0, irq_cmpa}, 16'h0000);
        gie = 1'b1;
        wr8(4'd8, 8'h00); #1;
        chk("R10 mask off", {15'h0, irq_cmpa}, 16'h0000);

        // R6 compare B
        wr16(4'd0, 16'h07F0);
        wr8(4'd10, 8'h01);
        repeat (30) @(negedge clk);
        wr8(4'd10, 8'h00);
        chk("R6 wave b toggled", {15'h0, wave_b}, 16'h0001);
        rd8(4'd9, b); chk("R6 flag b", {13'h0, b[2:0]}, 16'h0006);

        // R11 write-one clear, zero leaves alone
        wr8(4'd9, 8'h00); rd8(4'd9, b); chk("R11 zero write", {8'h0, b}, 16'h0006);
        wr8(4'd9, 8'h02); rd8(4'd9, b); chk("R11 clear a", {8'h0, b}, 16'h0004);
        wr8(4'd9, 8'hFF); rd8(4'd9, b); chk("R11 clear all", {8'h0, b}, 16'h0000);

        // R7 overflow at 0xFFFF
        wr16(4'd0, 16'hFFFD);
        wr8(4'd10, 8'h01);
        repeat (8) @(negedge clk);
        wr8(4'd10, 8'h00);
        rd8(4'd9, b); chk("R7 ovf flag", {15'h0, b[0]}, 16'h0001);
        rd16(4'd0, v); chk("R7 wrapped", {15'h0, (v > 16'h0 && v < 16'h20)}, 16'h0001);
        wr8(4'd8, 8'h01); #1;
        chk("R10 irq ovf", {15'h0, irq_ovf}, 16'h0001);
        wr8(4'd9, 8'hFF);

        // R8 capture from pin, stopped counter
        wr16(4'd0, 16'h3A5A);
        wr8(4'd8, 8'h20);
        pulse(1'b0);
        rd16(4'd6, v); chk("R8 pin capture", v, 16'h3A5A);
        rd8(4'd9, b); chk("R8 cap flag", {8'h0, b}, 16'h0020);
        chk("R10 irq cap", {15'h0, irq_cap}, 16'h0001);
        wr8(4'd9, 8'h20);
        // unselected comparator ignored
        wr16(4'd0, 16'h4444);
        pulse(1'b1);
        rd16(4'd6, v); chk("R8 cmp ignored", v, 16'h3A5A);
        rd8(4'd9, b); chk("R8 no flag", {8'h0, b}, 16'h0000);
        // comparator selected
        wr8(4'd10, 8'h02);
        pulse(1'b1);
        rd16(4'd6, v); chk("R8 cmp capture", v, 16'h4444);
        wr16(4'd0, 16'h5555);
        pulse(1'b0);
        rd16(4'd6, v); chk("R8 pin ignored", v, 16'h4444);
        wr8(4'd10, 8'h00);
        wr8(4'd9, 8'hFF);

        // R11 set and clear in the same cycle: set wins
        wr16(4'd0, 16'h0777);
        @(negedge clk); cap_pin = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        bus_addr = 4'd9; bus_wdata = 8'h20; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
        rd8(4'd9, b); chk("R11 set wins", {8'h0, b}, 16'h0020);
        rd16(4'd6, v); chk("R11 captured", v, 16'h0777);
        cap_pin = 1'b0;
        wr8(4'd9, 8'h20); rd8(4'd9, b); chk("R11 later clear", {8'h0, b}, 16'h0000);

        // R9 top from capture
        wr16(4'd0, 16'h0000);
        wr16(4'd6, 16'h0005);
        wr8(4'd10, 8'h05);
        pulse(1'b0);
        repeat (13) @(negedge clk);
        wr8(4'd10, 8'h04);
        rd16(4'd0, v); chk("R9 below top", {15'h0, v <= 16'h0005}, 16'h0001);
        rd16(4'd6, v); chk("R9 capture ignored", v, 16'h0005);
        rd8(4'd9, b); chk("R9 ovf", {8'h0, b}, 16'h0001);
        wr8(4'd10, 8'h00);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule